// File: doc/BRIEF.md
# Six-State Ring Control Sequencer

This block is the control unit of a small accumulator machine. A one-hot ring of six timing states advances by one position on every clock. The first three states fetch an instruction and the last three execute it. The sequencer sees only the 4-bit opcode, which the instruction register supplies over a direct path. From the current timing state and that opcode it drives a 12-line control word. The word steers the program counter, address register, memory, instruction register, accumulator, adder/subtracter, B register and output register.

The fetch states produce the same words for every instruction. The execute states follow the decoded opcode. A halt opcode freezes the ring and drops an active-low run flag, so no further fetch takes place until reset. The datapath registers and the memory sit outside this block.

Top module: `ring_sequencer`

## Requirements
- R1: While running, the timing state advances one position per clock through T1, T2, T3, T4, T5, T6 and wraps from T6 back to T1. Exactly one state is active at any time.
- R2: Bit order of `ctrl_word`, from bit 11 down to bit 0:
  - bit 11: PC increment (active high)
  - bit 10: PC onto bus (active high)
  - bit 9: address-register load (active low)
  - bit 8: memory read (active low)
  - bit 7: instruction-register load (active low)
  - bit 6: operand onto bus (active low)
  - bit 5: accumulator load (active low)
  - bit 4: accumulator onto bus (active high)
  - bit 3: subtract select (active high)
  - bit 2: adder result onto bus (active high)
  - bit 1: B load (active low)
  - bit 0: output-register load (active low)
  
  With no line asserted the word is 12'h3E3 (idle).
- R3: The fetch words are T1 = 12'h5E3, T2 = 12'hBE3 and T3 = 12'h263, whatever the opcode is.
- R4: Load (opcode 4'b0000) gives T4 = 12'h1A3, T5 = 12'h2C3 and T6 = idle.
- R5: Add (opcode 4'b0001) gives T4 = 12'h1A3, T5 = 12'h2E1 and T6 = 12'h3C7.
- R6: Subtract (opcode 4'b0010) matches add except at T6, which is 12'h3CF. Subtract select is high only there.
- R7: Output (opcode 4'b1110) gives T4 = 12'h3F2 and idle at T5 and T6.
- R8: Halt (opcode 4'b1111) shows idle at T4. On the clock edge that ends T4, `hold_n` falls to 0. From then on the ring stays frozen and the word stays idle until reset, whatever the opcode input does.
- R9: Any other opcode gives idle words in T4 to T6, after which fetch resumes at T1.
- R10: When `rst` is high at a clock edge, the ring returns to T1 and `hold_n` returns to 1. The next clock after `rst` is released moves to T2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Upper nibble of the instruction register |
| ctrl_word | output | 12 | Control lines, bit order as in R2 |
| hold_n | output | 1 | Run flag: 1 while running, 0 once halted |

## Verification
A ring that skipped, stuck or carried two hot bits would show at once as a wrong word at the ports. Every state has its own word, and the three fetch words differ from each other. A wrong state is therefore exposed within the cycle it occurs, and at the latest at the next T1. A lost or spurious halt shows as `hold_n` disagreeing one edge after T4, or as a fetch word appearing while halted. A mis-decoded opcode shows in the T4 to T6 words of that instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W   = 4;
  localparam int CW_W   = 12;
  localparam int NSTATE = 6;

  localparam logic [OP_W-1:0] OP_LOAD = 4'b0000;
  localparam logic [OP_W-1:0] OP_ADD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_SUB  = 4'b0010;
  localparam logic [OP_W-1:0] OP_SHOW = 4'b1110;
  localparam logic [OP_W-1:0] OP_STOP = 4'b1111;

  // control line positions
  localparam int B_PC_INC  = 11;
  localparam int B_PC_DRV  = 10;
  localparam int B_MAR_N   = 9;
  localparam int B_RD_N    = 8;
  localparam int B_IR_N    = 7;
  localparam int B_OPND_N  = 6;
  localparam int B_ACC_N   = 5;
  localparam int B_ACC_DRV = 4;
  localparam int B_SUB     = 3;
  localparam int B_ALU_DRV = 2;
  localparam int B_B_N     = 1;
  localparam int B_OUT_N   = 0;

  // all active-low lines high, active-high lines low
  localparam logic [CW_W-1:0] CW_IDLE = 12'h3E3;

  // ring positions
  localparam int S_T1 = 0;
  localparam int S_T2 = 1;
  localparam int S_T3 = 2;
  localparam int S_T4 = 3;
  localparam int S_T5 = 4;
  localparam int S_T6 = 5;
endpackage

// File: rtl/seq_ring.sv
module seq_ring #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [N-1:0] ring_q
);
  localparam logic [N-1:0] RING_INIT = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)
      ring_q <= RING_INIT;
    else if (adv)
      ring_q <= {ring_q[N-2:0], ring_q[N-1]};
  end

  // R1: exactly one timing state active
  p_ring_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(ring_q) == 1);

  // R8: a frozen ring holds its position
  p_ring_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ring_q));
endmodule

// File: rtl/seq_halt.sv
module seq_halt
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_t4,
  input  logic [OP_W-1:0] opcode,
  output logic            hold_n
);
  logic stop_hit;
  assign stop_hit = in_t4 && (opcode == OP_STOP);

  always_ff @(posedge clk) begin
    if (rst)
      hold_n <= 1'b1;
    else if (stop_hit)
      hold_n <= 1'b0;
  end

  // R8: once halted, stays halted until reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> !hold_n);
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int N = NSTATE
) (
  input  logic [N-1:0]    ring,
  input  logic [OP_W-1:0] opcode,
  input  logic            hold_n,
  output logic [CW_W-1:0] ctrl
);
  logic is_load, is_arith, is_sub, is_show;

  always_comb begin
    is_load  = (opcode == OP_LOAD);
    is_sub   = (opcode == OP_SUB);
    is_arith = (opcode == OP_ADD) || is_sub;
    is_show  = (opcode == OP_SHOW);
  end

  always_comb begin
    ctrl = CW_IDLE;
    if (hold_n) begin
      if (ring[S_T1]) begin
        ctrl[B_PC_DRV] = 1'b1;
        ctrl[B_MAR_N]  = 1'b0;
      end
      if (ring[S_T2])
        ctrl[B_PC_INC] = 1'b1;
      if (ring[S_T3]) begin
        ctrl[B_RD_N] = 1'b0;
        ctrl[B_IR_N] = 1'b0;
      end
      if (ring[S_T4]) begin
        if (is_load || is_arith) begin
          ctrl[B_OPND_N] = 1'b0;
          ctrl[B_MAR_N]  = 1'b0;
        end
        if (is_show) begin
          ctrl[B_ACC_DRV] = 1'b1;
          ctrl[B_OUT_N]   = 1'b0;
        end
      end
      if (ring[S_T5]) begin
        if (is_load) begin
          ctrl[B_RD_N]  = 1'b0;
          ctrl[B_ACC_N] = 1'b0;
        end
        if (is_arith) begin
          ctrl[B_RD_N] = 1'b0;
          ctrl[B_B_N]  = 1'b0;
        end
      end
      if (ring[S_T6] && is_arith) begin
        ctrl[B_ALU_DRV] = 1'b1;
        ctrl[B_ACC_N]   = 1'b0;
        ctrl[B_SUB]     = is_sub;
      end
    end
  end
endmodule

// File: rtl/ring_sequencer.sv
module ring_sequencer
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic [CW_W-1:0] ctrl_word,
  output logic            hold_n
);
  logic [NSTATE-1:0] ring;
  logic              adv;

  assign adv = hold_n && !(ring[S_T4] && opcode == OP_STOP);

  seq_ring #(.N(NSTATE)) ring_i (
    .clk(clk), .rst(rst), .adv(adv), .ring_q(ring)
  );

  seq_halt halt_i (
    .clk(clk), .rst(rst), .in_t4(ring[S_T4]), .opcode(opcode), .hold_n(hold_n)
  );

  seq_decode #(.N(NSTATE)) dec_i (
    .ring(ring), .opcode(opcode), .hold_n(hold_n), .ctrl(ctrl_word)
  );

  // R1: after the last execute state, fetch restarts at T1
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (hold_n && ring[S_T6]) |=> ctrl_word == 12'h5E3);

  // R3: PC increment is a single-cycle pulse
  p_inc_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[B_PC_INC] |=> !ctrl_word[B_PC_INC]);

  // R8: halted machine asserts nothing
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !hold_n |-> ctrl_word == CW_IDLE);

  // R10: reset leaves the machine running at T1
  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (hold_n && ctrl_word == 12'h5E3));
endmodule

// File: tb/ring_sequencer_tb_top.sv
`timescale 1ns/1ps
module ring_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic [11:0] ctrl_word;
  logic        hold_n;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [11:0] IDLE = 12'h3E3;
  localparam logic [11:0] W_T1 = 12'h5E3;
  localparam logic [11:0] W_T2 = 12'hBE3;
  localparam logic [11:0] W_T3 = 12'h263;

  always #5 clk = ~clk;

  ring_sequencer dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .ctrl_word(ctrl_word), .hold_n(hold_n)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R10: reset, then confirm T1 with run flag high
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R10 reset word", ctrl_word, W_T1);
    check("R10 reset hold_n", {11'd0, hold_n}, 12'd1);
  endtask

  // Runs one instruction from T1; the opcode is wrong until T3 to show fetch ignores it.
  task automatic run_instr(input string tag, input logic [3:0] op,
                           input logic [11:0] e4, input logic [11:0] e5,
                           input logic [11:0] e6);
    opcode = ~op;
    check({"R3 T1 ", tag}, ctrl_word, W_T1);
    step();
    check({"R3 T2 ", tag}, ctrl_word, W_T2);
    step();
    opcode = op;
    check({"R3 T3 ", tag}, ctrl_word, W_T3);
    step();
    check({tag, " T4"}, ctrl_word, e4);
    step();
    check({tag, " T5"}, ctrl_word, e5);
    step();
    check({tag, " T6"}, ctrl_word, e6);
    step();
  endtask

  task automatic test_halt();
    run_instr("R4 load", 4'b0000, 12'h1A3, 12'h2C3, IDLE);
    opcode = 4'b0001;
    check("R3 T1 pre-halt", ctrl_word, W_T1);
    step(); step();
    opcode = 4'b1111;
    check("R3 T3 pre-halt", ctrl_word, W_T3);
    step();
    check("R8 halt T4 word", ctrl_word, IDLE);
    check("R8 halt T4 hold_n", {11'd0, hold_n}, 12'd1);
    step();
    check("R8 halted hold_n", {11'd0, hold_n}, 12'd0);
    check("R8 halted word", ctrl_word, IDLE);
    opcode = 4'b0000;
    for (int i = 0; i < 8; i++) begin
      step();
      check("R8 frozen word", ctrl_word, IDLE);
      check("R8 frozen hold_n", {11'd0, hold_n}, 12'd0);
    end
    do_reset();
    step();
    check("R10 after halt reset T2", ctrl_word, W_T2);
    do_reset();
  endtask

  task automatic test_mid_reset();
    step(); step();
    check("R1 mid T3", ctrl_word, W_T3);
    do_reset();
    step();
    check("R10 resume T2", ctrl_word, W_T2);
    do_reset();
  endtask

  initial begin
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    check("R10 initial word", ctrl_word, W_T1);
    check("R10 initial hold_n", {11'd0, hold_n}, 12'd1);
    run_instr("R4 load", 4'b0000, 12'h1A3, 12'h2C3, IDLE);
    run_instr("R5 add", 4'b0001, 12'h1A3, 12'h2E1, 12'h3C7);
    run_instr("R6 sub", 4'b0010, 12'h1A3, 12'h2E1, 12'h3CF);
    run_instr("R7 out", 4'b1110, 12'h3F2, IDLE, IDLE);
    run_instr("R9 undef5", 4'b0101, IDLE, IDLE, IDLE);
    run_instr("R9 undef3", 4'b0011, IDLE, IDLE, IDLE);
    run_instr("R1 wrap add", 4'b0001, 12'h1A3, 12'h2E1, 12'h3C7);
    check("R2 idle hold_n", {11'd0, hold_n}, 12'd1);
    test_halt();
    test_mid_reset();
    run_instr("R6 sub after reset", 4'b0010, 12'h1A3, 12'h2E1, 12'h3CF);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule